// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This decode-stage block looks at the two oldest decoded instructions in an in-order machine and decides, once per clock, whether both of them can start together in two parallel execution pipes. The older instruction always goes to the primary pipe. The younger one goes to the secondary pipe only when a fixed set of pairing rules allows it. When it is refused, the younger instruction stays in the queue. On the next cycle it becomes the older instruction of a new candidate pair.

Each slot gives class flags and register fields. The class flags are: simple (no microcode sequencing needed), unconditional or conditional control transfer, flag producer, and primary-pipe-only. The register fields are one destination with a write enable and, for the younger slot, a parameterised number of source indices, each with its own enable. The decision is registered. The instruction queue gets back a count of the slots it may retire: none, one or two.

Top module: `dual_issue_pair`

## Requirements
- R1: While rst_n is low, issue_primary and issue_secondary are 0 and consumed is 2'b00.
- R2: Every decision is visible one rising clock edge after its inputs are sampled. When p0_valid is 0, nothing issues and consumed is 2'b00.
- R3: When p0_valid is 1 and p1_valid is 0, only issue_primary is set and consumed is 2'b01.
- R4: When both slots are valid and no rule below blocks, both issue enables are set and consumed is 2'b10. issue_secondary is never 1 without issue_primary.
- R5: If either instruction has its simple flag at 0 (it needs microcode), the older one issues alone with consumed 2'b01.
- R6: If the older instruction is a control transfer (p0_branch = 1), it issues alone.
- R7: If p0_wr_en is 1 and p0_wr_reg equals any younger source whose enable bit is 1, the older one issues alone. A matching source with its enable at 0, or p0_wr_en at 0, does not block.
- R8: If both write enables are 1 and both destination indices are equal, the older one issues alone. If either write enable is 0, equal indices do not block.
- R9: A flag producer followed by a conditional branch reading the flags (p0_sets_flags = 1, p1_cond_branch = 1) may pair when FLAG_PAIR = 1. With FLAG_PAIR = 0 the same pair is refused.
- R10: A younger instruction with p1_pipe0_only = 1 never issues to the secondary pipe. The older one then issues alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_valid | input | 1 | Older slot holds an instruction |
| p0_simple | input | 1 | Older instruction needs no microcode |
| p0_branch | input | 1 | Older instruction is a control transfer |
| p0_sets_flags | input | 1 | Older instruction writes the flags |
| p0_wr_en | input | 1 | Older instruction writes a register |
| p0_wr_reg | input | REG_W | Older destination index |
| p1_valid | input | 1 | Younger slot holds an instruction |
| p1_simple | input | 1 | Younger instruction needs no microcode |
| p1_pipe0_only | input | 1 | Younger instruction needs primary-pipe resources |
| p1_cond_branch | input | 1 | Younger instruction is a conditional branch on the flags |
| p1_wr_en | input | 1 | Younger instruction writes a register |
| p1_wr_reg | input | REG_W | Younger destination index |
| p1_rd_en | input | NUM_SRC | Per-source read enables of the younger instruction |
| p1_rd_reg | input | NUM_SRC*REG_W | Younger source indices, source i at bits [i*REG_W +: REG_W] |
| issue_primary | output | 1 | Older instruction starts in the primary pipe |
| issue_secondary | output | 1 | Younger instruction starts in the secondary pipe |
| consumed | output | 2 | Slots retired from the queue: 0, 1 or 2 |

## Verification
The bench builds two copies: u0 with the defaults (REG_W = 3, NUM_SRC = 2, FLAG_PAIR = 1) and u1 with FLAG_PAIR = 0. Both copies get the same stimulus, so the flag-producer-to-branch pair can be seen accepted by one and refused by the other. The 3-bit register space makes equal indices frequent in random traffic. That brings read-after-write and write-after-write collisions, including matches on disabled sources, within easy reach. Both source positions are exercised, so a loop that compares only one source would be caught.

// File: rtl/dip_pkg.sv
package dip_pkg;
   typedef enum logic [1:0] {
      TAKE_NONE = 2'b00,
      TAKE_ONE  = 2'b01,
      TAKE_TWO  = 2'b10
   } take_e;

   function automatic take_e take_of(input logic head_live, input logic dual);
      if (!head_live) return TAKE_NONE;
      if (dual)       return TAKE_TWO;
      return TAKE_ONE;
   endfunction
endpackage

// File: rtl/dip_reg_hazard.sv
module dip_reg_hazard #(
   parameter int REG_W   = 3,
   parameter int NUM_SRC = 2
) (
   input  logic                     p0_wr_en,
   input  logic [REG_W-1:0]         p0_wr_reg,
   input  logic                     p1_wr_en,
   input  logic [REG_W-1:0]         p1_wr_reg,
   input  logic [NUM_SRC-1:0]       p1_rd_en,
   input  logic [NUM_SRC*REG_W-1:0] p1_rd_reg,
   output logic                     raw_hit,
   output logic                     waw_hit
);
   logic [NUM_SRC-1:0] src_match;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign src_match[i] = p1_rd_en[i] && (p1_rd_reg[i*REG_W +: REG_W] == p0_wr_reg);
   end

   assign raw_hit = p0_wr_en && (|src_match);
   assign waw_hit = p0_wr_en && p1_wr_en && (p0_wr_reg == p1_wr_reg);
endmodule

// File: rtl/dip_class_rules.sv
module dip_class_rules #(
   parameter bit FLAG_PAIR = 1'b1
) (
   input  logic p0_simple,
   input  logic p0_branch,
   input  logic p0_sets_flags,
   input  logic p1_simple,
   input  logic p1_pipe0_only,
   input  logic p1_cond_branch,
   output logic class_ok
);
   logic flag_ok;

   if (FLAG_PAIR) begin : g_flag_fuse
      assign flag_ok = 1'b1;
      wire unused_flag_bits = &{1'b0, p0_sets_flags, p1_cond_branch};
   end else begin : g_flag_split
      assign flag_ok = !(p0_sets_flags && p1_cond_branch);
   end

   assign class_ok = p0_simple && p1_simple && !p0_branch && !p1_pipe0_only && flag_ok;
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
   import dip_pkg::*;
#(
   parameter int REG_W     = 3,
   parameter int NUM_SRC   = 2,
   parameter bit FLAG_PAIR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     p0_valid,
   input  logic                     p0_simple,
   input  logic                     p0_branch,
   input  logic                     p0_sets_flags,
   input  logic                     p0_wr_en,
   input  logic [REG_W-1:0]         p0_wr_reg,
   input  logic                     p1_valid,
   input  logic                     p1_simple,
   input  logic                     p1_pipe0_only,
   input  logic                     p1_cond_branch,
   input  logic                     p1_wr_en,
   input  logic [REG_W-1:0]         p1_wr_reg,
   input  logic [NUM_SRC-1:0]       p1_rd_en,
   input  logic [NUM_SRC*REG_W-1:0] p1_rd_reg,
   output logic                     issue_primary,
   output logic                     issue_secondary,
   output logic [1:0]               consumed
);
   localparam int SRC_BITS = NUM_SRC * REG_W;

   initial begin
      if (REG_W < 1 || REG_W > 8) $fatal(1, "dual_issue_pair: REG_W out of range");
      if (NUM_SRC < 1 || NUM_SRC > 4) $fatal(1, "dual_issue_pair: NUM_SRC out of range");
      if (SRC_BITS > 32) $fatal(1, "dual_issue_pair: source field too wide");
   end

   logic raw_hit, waw_hit, class_ok, pair_ok;
   take_e take_d, take_q;
   logic pri_q, sec_q;

   dip_reg_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_hazard (
      .p0_wr_en (p0_wr_en),
      .p0_wr_reg(p0_wr_reg),
      .p1_wr_en (p1_wr_en),
      .p1_wr_reg(p1_wr_reg),
      .p1_rd_en (p1_rd_en),
      .p1_rd_reg(p1_rd_reg),
      .raw_hit  (raw_hit),
      .waw_hit  (waw_hit)
   );

   dip_class_rules #(.FLAG_PAIR(FLAG_PAIR)) u_class (
      .p0_simple     (p0_simple),
      .p0_branch     (p0_branch),
      .p0_sets_flags (p0_sets_flags),
      .p1_simple     (p1_simple),
      .p1_pipe0_only (p1_pipe0_only),
      .p1_cond_branch(p1_cond_branch),
      .class_ok      (class_ok)
   );

   assign pair_ok = p0_valid && p1_valid && class_ok && !raw_hit && !waw_hit;
   assign take_d  = take_of(p0_valid, pair_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_q  <= 1'b0;
         sec_q  <= 1'b0;
         take_q <= TAKE_NONE;
      end else begin
         pri_q  <= p0_valid;
         sec_q  <= pair_ok;
         take_q <= take_d;
      end
   end

   assign issue_primary   = pri_q;
   assign issue_secondary = sec_q;
   assign consumed        = take_q;

   AST_SEC_NEEDS_PRI: assert property (@(posedge clk) disable iff (!rst_n)
      issue_secondary |-> issue_primary); // R4
   AST_COUNT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      consumed == {issue_secondary, issue_primary && !issue_secondary}); // R3
   AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      !p0_valid |=> (consumed == 2'b00 && !issue_primary)); // R2
   AST_MICROCODE_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && (!p0_simple || !p1_simple)) |=> !issue_secondary); // R5
   AST_JUMP_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_valid && p0_branch) |=> !issue_secondary); // R6
   AST_WAW_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_wr_en && p1_wr_en && p0_wr_reg == p1_wr_reg) |=> !issue_secondary); // R8
   AST_PIPE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      p1_pipe0_only |=> !issue_secondary); // R10

   if (!FLAG_PAIR) begin : g_flag_chk
      AST_FLAG_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
         (p0_sets_flags && p1_cond_branch) |=> !issue_secondary); // R9
   end
endmodule

// File: tb/sim_dual_issue_pair.sv
module sim_dual_issue_pair;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 3;
   localparam int NS = 2;

   typedef struct packed {
      logic          valid;
      logic          simple;
      logic          branch;
      logic          sets_flags;
      logic          cond_branch;
      logic          pipe0_only;
      logic          wr_en;
      logic [RW-1:0] wr_reg;
      logic [NS-1:0] rd_en;
      logic [NS*RW-1:0] rd_reg;
   } ins_t;

   typedef struct {
      logic  ip;
      logic  sec0;
      logic  sec1;
      string tag0;
      string tag1;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   ins_t a, b;
   logic ip0, is0, ip1, is1;
   logic [1:0] c0, c1;
   exp_t q[$];
   int vectors = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_issue_pair #(.REG_W(RW), .NUM_SRC(NS), .FLAG_PAIR(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .p0_valid(a.valid), .p0_simple(a.simple), .p0_branch(a.branch),
      .p0_sets_flags(a.sets_flags), .p0_wr_en(a.wr_en), .p0_wr_reg(a.wr_reg),
      .p1_valid(b.valid), .p1_simple(b.simple), .p1_pipe0_only(b.pipe0_only),
      .p1_cond_branch(b.cond_branch), .p1_wr_en(b.wr_en), .p1_wr_reg(b.wr_reg),
      .p1_rd_en(b.rd_en), .p1_rd_reg(b.rd_reg),
      .issue_primary(ip0), .issue_secondary(is0), .consumed(c0));

   dual_issue_pair #(.REG_W(RW), .NUM_SRC(NS), .FLAG_PAIR(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n),
      .p0_valid(a.valid), .p0_simple(a.simple), .p0_branch(a.branch),
      .p0_sets_flags(a.sets_flags), .p0_wr_en(a.wr_en), .p0_wr_reg(a.wr_reg),
      .p1_valid(b.valid), .p1_simple(b.simple), .p1_pipe0_only(b.pipe0_only),
      .p1_cond_branch(b.cond_branch), .p1_wr_en(b.wr_en), .p1_wr_reg(b.wr_reg),
      .p1_rd_en(b.rd_en), .p1_rd_reg(b.rd_reg),
      .issue_primary(ip1), .issue_secondary(is1), .consumed(c1));

   // Reference model written from the requirements.
   function automatic logic model(input ins_t x, input ins_t y, input bit fp, output string tag);
      logic raw = 1'b0;
      for (int i = 0; i < NS; i++)
         if (y.rd_en[i] && y.rd_reg[i*RW +: RW] == x.wr_reg) raw = 1'b1;
      raw = raw && x.wr_en;
      if (!x.valid)                         begin tag = "R2";  return 1'b0; end
      if (!y.valid)                         begin tag = "R3";  return 1'b0; end
      if (!x.simple || !y.simple)           begin tag = "R5";  return 1'b0; end
      if (x.branch)                         begin tag = "R6";  return 1'b0; end
      if (y.pipe0_only)                     begin tag = "R10"; return 1'b0; end
      if (raw)                              begin tag = "R7";  return 1'b0; end
      if (x.wr_en && y.wr_en && x.wr_reg == y.wr_reg) begin tag = "R8"; return 1'b0; end
      if (x.sets_flags && y.cond_branch) begin
         tag = "R9";
         return fp;
      end
      tag = "R4";
      return 1'b1;
   endfunction

   function automatic ins_t plain(input logic [RW-1:0] dst, input logic [RW-1:0] s0, input logic [RW-1:0] s1);
      ins_t t;
      t = '0;
      t.valid = 1'b1; t.simple = 1'b1; t.wr_en = 1'b1; t.wr_reg = dst;
      t.rd_en = 2'b11; t.rd_reg = {s1, s0};
      return t;
   endfunction

   task automatic drive(input ins_t x, input ins_t y);
      exp_t e;
      @(negedge clk);
      a = x;
      b = y;
      e.ip   = x.valid;
      e.sec0 = model(x, y, 1'b1, e.tag0);
      e.sec1 = model(x, y, 1'b0, e.tag1);
      q.push_back(e);
   endtask

   task automatic cmp(input string tag, input string what, input int act, input int ex);
      if (act != ex) begin
         bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, ex);
      end
   endtask

   // Monitor: each pushed item is due one edge after it was driven.
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         vectors++;
         cmp(e.tag0, "u0 issue_primary",   ip0, e.ip);
         cmp(e.tag0, "u0 issue_secondary", is0, e.sec0);
         cmp(e.tag0, "u0 consumed",        c0,  e.ip + e.sec0);
         cmp(e.tag1, "u1 issue_primary",   ip1, e.ip);
         cmp(e.tag1, "u1 issue_secondary", is1, e.sec1);
         cmp(e.tag1, "u1 consumed",        c1,  e.ip + e.sec1);
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end

   initial begin
      ins_t x, y;
      a = plain(3'd1, 3'd2, 3'd3);
      b = plain(3'd1, 3'd2, 3'd3);
      repeat (3) @(posedge clk);
      @(negedge clk);
      vectors++;
      cmp("R1", "reset issue_primary",   ip0, 0);
      cmp("R1", "reset issue_secondary", is0, 0);
      cmp("R1", "reset consumed",        c0,  0);
      cmp("R1", "reset consumed u1",     c1,  0);
      rst_n = 1'b1;

      // R4 independent pair
      drive(plain(3'd1, 3'd2, 3'd3), plain(3'd4, 3'd5, 3'd6));
      // R2 empty head
      x = plain(3'd1, 3'd2, 3'd3); x.valid = 1'b0;
      drive(x, plain(3'd4, 3'd5, 3'd6));
      // R3 lone head
      y = plain(3'd4, 3'd5, 3'd6); y.valid = 1'b0;
      drive(plain(3'd1, 3'd2, 3'd3), y);
      // R5 microcoded in either slot
      x = plain(3'd1, 3'd2, 3'd3); x.simple = 1'b0;
      drive(x, plain(3'd4, 3'd5, 3'd6));
      y = plain(3'd4, 3'd5, 3'd6); y.simple = 1'b0;
      drive(plain(3'd1, 3'd2, 3'd3), y);
      // R6 head is a jump
      x = plain(3'd1, 3'd2, 3'd3); x.branch = 1'b1;
      drive(x, plain(3'd4, 3'd5, 3'd6));
      // R7 read-after-write on source 0, on source 1, then disabled source
      drive(plain(3'd1, 3'd2, 3'd3), plain(3'd4, 3'd1, 3'd6));
      drive(plain(3'd1, 3'd2, 3'd3), plain(3'd4, 3'd5, 3'd1));
      y = plain(3'd4, 3'd5, 3'd1); y.rd_en = 2'b01;
      drive(plain(3'd1, 3'd2, 3'd3), y);
      x = plain(3'd1, 3'd2, 3'd3); x.wr_en = 1'b0;
      drive(x, plain(3'd4, 3'd1, 3'd1));
      // R8 same destination, then one write disabled
      drive(plain(3'd7, 3'd2, 3'd3), plain(3'd7, 3'd5, 3'd6));
      y = plain(3'd7, 3'd5, 3'd6); y.wr_en = 1'b0;
      drive(plain(3'd7, 3'd2, 3'd3), y);
      // R9 flag producer then conditional branch
      x = plain(3'd1, 3'd2, 3'd3); x.sets_flags = 1'b1;
      y = plain(3'd4, 3'd5, 3'd6); y.cond_branch = 1'b1; y.wr_en = 1'b0;
      drive(x, y);
      // R10 younger needs primary-pipe resources
      y = plain(3'd4, 3'd5, 3'd6); y.pipe0_only = 1'b1;
      drive(plain(3'd1, 3'd2, 3'd3), y);
      // Mixed traffic
      for (int n = 0; n < 600; n++) begin
         ins_t rx, ry;
         rx = ins_t'({$urandom, $urandom});
         ry = ins_t'({$urandom, $urandom});
         rx.valid  = ($urandom_range(0, 7) != 0);
         ry.valid  = ($urandom_range(0, 7) != 0);
         rx.simple = ($urandom_range(0, 5) != 0);
         ry.simple = ($urandom_range(0, 5) != 0);
         rx.branch = ($urandom_range(0, 5) == 0);
         ry.pipe0_only = ($urandom_range(0, 5) == 0);
         drive(rx, ry);
      end
      @(negedge clk);
      a = '0;
      b = '0;
      repeat (3) @(posedge clk);
      #2;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end
endmodule